// File: doc/BRIEF.md
# Condition Evaluation and Conditional Select Unit

This unit holds a four-bit status register made of negative (N), zero (Z), carry (C) and overflow (V) bits. It tests that register against a four-bit condition code, and from the outcome it picks or alters one of two data operands. A flag-producing stage outside the unit loads new status bits by raising a write strobe. On every cycle a consumer presents a condition code, a select operation and two operands. One clock later it receives the pass/fail outcome and the selected value.

Six operations are provided. If the condition passes, the four selects return operand A. If it fails, they return B, B+1, the bitwise inverse of B, or the two's-complement negation of B. The two set forms are built from the increment and invert selects: both operands are forced to zero and the condition is inverted, which turns the outcome into 1/0 or all-ones/0. A 32-bit mode works on the low half of the operands and returns a zero-extended result.

Top module: `cond_select_unit`

## Requirements
- R1: After synchronous reset, `res`, `cond_pass` and `flags_q` are all zero.
- R2: `flags_q` takes the value of `flag_in` (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V) at a clock edge where `flag_wr` is 1. At every other edge it holds its value, whatever `flag_in` carries.
- R3: Condition codes 0 to 7 pass as follows: 0 when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0, 4 when N=1, 5 when N=0, 6 when V=1, 7 when V=0.
- R4: Condition codes 8 to 13 pass as follows: 8 when C=1 and Z=0, 9 as the complement of 8, 10 when N=V, 11 when N!=V, 12 when Z=0 and N=V, 13 as the complement of 12.
- R5: Condition codes 14 and 15 always pass.
- R6: For op 0 (plain select), `res` is A on pass and B on fail. Op codes 6 and 7 behave as op 0.
- R7: For op 1 (increment select), `res` is A on pass and B+1 on fail, modulo the data width.
- R8: For op 2 (invert select), `res` is A on pass and ~B on fail.
- R9: For op 3 (negate select), `res` is A on pass and -B on fail, modulo the data width.
- R10: For op 4 (set), `res` is 1 when the condition passes and 0 when it fails. Codes 14 and 15 give 0, because the inverted condition is still "always".
- R11: For op 5 (set all ones), `res` is all ones (within the active width) when the condition passes and 0 when it fails. Codes 14 and 15 give 0.
- R12: With `word32`=1, only bits 31:0 of the operands take part, the operation is done modulo 2^32, and bits 63:32 of `res` are zero.
- R13: `res` and `cond_pass` show the result one clock edge after the inputs are presented. The condition uses the flags held before that edge, so a flag write at the same edge does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_wr | input | 1 | Strobe that loads the status register |
| flag_in | input | 4 | New flags: N, Z, C, V from bit 3 down to bit 0 |
| cond | input | 4 | Condition code |
| op | input | 3 | Select operation (0..5; 6 and 7 act as 0) |
| word32 | input | 1 | 32-bit mode: zero-extended result |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| flags_q | output | 4 | Current status register |
| cond_pass | output | 1 | Registered outcome of `cond` against the flags |
| res | output | 64 | Registered select result |

## Verification
Flag writes appear on `flags_q` after the edge that takes the strobe. Condition outcomes and select results appear after the edge that follows their inputs. The bench therefore drives inputs on the falling edge and checks at the next falling edge, with exactly one rising edge in between. The sweep covers all sixteen flag values, all sixteen codes, all eight op codes and both widths, and it writes the flags one cycle before each group of operations. One dedicated case writes new flags at the same edge as an operation and checks that the old flags decide the outcome.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam logic [2:0] OP_SEL  = 3'd0;
  localparam logic [2:0] OP_SINC = 3'd1;
  localparam logic [2:0] OP_SINV = 3'd2;
  localparam logic [2:0] OP_SNEG = 3'd3;
  localparam logic [2:0] OP_SET  = 3'd4;
  localparam logic [2:0] OP_SETM = 3'd5;

  localparam logic [2:0] CC_ALWAYS_PAIR = 3'b111;

endpackage

// File: rtl/csel_flag_reg.sv
module csel_flag_reg
  import csel_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  nzcv_t flag_d,
  output nzcv_t flag_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else if (wr_en) begin
      flag_q <= flag_d;
    end
  end

  // R2: the register holds without a strobe
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (flag_q == $past(flag_q)));

  // R2: the register loads on a strobe
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flag_q == $past(flag_d)));

endmodule

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
  import csel_pkg::*;
(
  input  nzcv_t      flags,
  input  logic [3:0] code,
  output logic       pass
);

  logic base;

  always_comb begin
    case (code[3:1])
      3'd0:    base = flags.z;
      3'd1:    base = flags.c;
      3'd2:    base = flags.n;
      3'd3:    base = flags.v;
      3'd4:    base = flags.c & ~flags.z;
      3'd5:    base = (flags.n == flags.v);
      3'd6:    base = ~flags.z & (flags.n == flags.v);
      default: base = 1'b1;
    endcase
    // odd codes complement their even partner, except the always pair
    if (code[0] && (code[3:1] != CC_ALWAYS_PAIR)) begin
      pass = ~base;
    end else begin
      pass = base;
    end
  end

endmodule

// File: rtl/csel_select_core.sv
module csel_select_core
  import csel_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [2:0]        op,
  input  logic              pass_dir,
  input  logic              pass_inv,
  input  logic              w32,
  output logic [DATA_W-1:0] y
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic              set_form;
  logic              take_a;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] a_e;
  logic [DATA_W-1:0] b_e;
  logic [DATA_W-1:0] alt;

  always_comb begin
    set_form = (op == OP_SET) || (op == OP_SETM);
    // set forms use the inverted condition with zero operands
    take_a   = set_form ? pass_inv : pass_dir;
    mask     = w32 ? LOW_MASK : {DATA_W{1'b1}};
    a_e      = set_form ? '0 : (a & mask);
    b_e      = set_form ? '0 : (b & mask);
    case (op)
      OP_SINC, OP_SET:  alt = b_e + ONE;
      OP_SINV, OP_SETM: alt = ~b_e;
      OP_SNEG:          alt = ~b_e + ONE;
      default:          alt = b_e;
    endcase
    y = (take_a ? a_e : alt) & mask;
  end

endmodule

// File: rtl/cond_select_unit.sv
module cond_select_unit
  import csel_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_wr,
  input  logic [3:0]        flag_in,
  input  logic [3:0]        cond,
  input  logic [2:0]        op,
  input  logic              word32,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [3:0]        flags_q,
  output logic              cond_pass,
  output logic [DATA_W-1:0] res
);

  localparam int N_EVAL = 2;

  nzcv_t             flag_d;
  nzcv_t             flag_cur;
  logic [N_EVAL-1:0] pass_v;
  logic [DATA_W-1:0] sel_y;

  assign flag_d  = flag_in;
  assign flags_q = flag_cur;

  csel_flag_reg u_flags (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (flag_wr),
    .flag_d (flag_d),
    .flag_q (flag_cur)
  );

  // evaluator 0 tests the code as given, evaluator 1 its inverse
  for (genvar gi = 0; gi < N_EVAL; gi++) begin : g_eval
    csel_cond_eval u_eval (
      .flags (flag_cur),
      .code  (cond ^ 4'(gi)),
      .pass  (pass_v[gi])
    );
  end

  csel_select_core #(.DATA_W(DATA_W)) u_core (
    .a        (opa),
    .b        (opb),
    .op       (op),
    .pass_dir (pass_v[0]),
    .pass_inv (pass_v[1]),
    .w32      (word32),
    .y        (sel_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      cond_pass <= 1'b0;
    end else begin
      res       <= sel_y;
      cond_pass <= pass_v[0];
    end
  end

  // R5: the always pair passes one cycle later
  p_always_r5: assert property (@(posedge clk) disable iff (rst)
    (cond[3:1] == CC_ALWAYS_PAIR) |=> cond_pass);

  // R12: narrow mode leaves the upper half clear
  p_narrow_r12: assert property (@(posedge clk) disable iff (rst)
    word32 |=> (res[DATA_W-1:DATA_W/2] == '0));

  // R10: the set form mirrors the outcome of the condition
  p_set_r10: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_SET) && (cond[3:1] != CC_ALWAYS_PAIR)) |=>
      (res == {{(DATA_W-1){1'b0}}, cond_pass}));

  // R6: plain select with an always code forwards operand A
  p_plain_r6: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_SEL) && !word32 && (cond[3:1] == CC_ALWAYS_PAIR)) |=>
      (res == $past(opa)));

  // R11: the all-ones form yields zero or a full word
  p_setm_r11: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_SETM) && !word32) |=> ((res == '0) || (&res)));

endmodule

// File: tb/cond_select_unit_tb_top.sv
`timescale 1ns/1ps
module cond_select_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flag_wr = 1'b0;
  logic [3:0]  flag_in = '0;
  logic [3:0]  cond = '0;
  logic [2:0]  op = '0;
  logic        word32 = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [3:0]  flags_q;
  logic        cond_pass;
  logic [63:0] res;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cond_select_unit #(.DATA_W(64)) dut_i (
    .clk(clk), .rst(rst), .flag_wr(flag_wr), .flag_in(flag_in),
    .cond(cond), .op(op), .word32(word32), .opa(opa), .opb(opb),
    .flags_q(flags_q), .cond_pass(cond_pass), .res(res)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic mpass(input logic [3:0] f, input logic [3:0] c);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !(cy && !z);
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return !(!z && (n == v));
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [63:0] mres(input logic [2:0] o, input logic [63:0] a,
                                       input logic [63:0] b, input logic [3:0] f,
                                       input logic [3:0] c, input logic w);
    logic [63:0] mask, am, bm, r;
    logic p, real_pass;
    mask = w ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;
    am = a & mask;
    bm = b & mask;
    p = mpass(f, c);
    real_pass = p && (c < 4'd14);
    case (o)
      3'd1: r = p ? am : bm + 64'd1;
      3'd2: r = p ? am : ~bm;
      3'd3: r = p ? am : 64'd0 - bm;
      3'd4: r = real_pass ? 64'd1 : 64'd0;
      3'd5: r = real_pass ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0;
      default: r = p ? am : bm;
    endcase
    return r & mask;
  endfunction

  function automatic string req_res(input logic [2:0] o, input logic w);
    if (w) return "R12";
    case (o)
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R10";
      3'd5: return "R11";
      default: return "R6";
    endcase
  endfunction

  function automatic string req_cond(input logic [3:0] c);
    if (c < 4'd8) return "R3";
    if (c < 4'd14) return "R4";
    return "R5";
  endfunction

  task automatic set_flags(input logic [3:0] f);
    @(negedge clk);
    flag_wr = 1'b1;
    flag_in = f;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [3:0] c, input logic [63:0] a,
                        input logic [63:0] b, input logic w);
    @(negedge clk);
    op = o; cond = c; opa = a; opb = b; word32 = w;
    @(negedge clk);
  endtask

  function automatic logic [63:0] b_pattern(input int k);
    case (k % 5)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7FFF_FFFF_FFFF_FFFF;
      3: return 64'h0000_0000_FFFF_FFFF;
      default: return 64'h8000_0000_8000_0000;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    chk("R1 res", res, 64'd0);
    chk("R1 cond_pass", {63'd0, cond_pass}, 64'd0);
    chk("R1 flags", {60'd0, flags_q}, 64'd0);

    // R2: no strobe, flags hold
    set_flags(4'b0101);
    chk("R2 load", {60'd0, flags_q}, 64'h5);
    @(negedge clk);
    flag_in = 4'b1010;
    @(negedge clk);
    chk("R2 hold", {60'd0, flags_q}, 64'h5);
    run_op(3'd0, 4'd4, 64'h11, 64'h22, 1'b0);
    chk("R2 hold MI", res, 64'h22);

    // R13: same-edge flag write does not affect the op
    set_flags(4'b0000);
    @(negedge clk);
    flag_wr = 1'b1; flag_in = 4'b0100;
    op = 3'd0; cond = 4'd0; opa = 64'd1; opb = 64'd2; word32 = 1'b0;
    @(negedge clk);
    flag_wr = 1'b0;
    chk("R13 old flags res", res, 64'd2);
    chk("R13 old flags pass", {63'd0, cond_pass}, 64'd0);
    chk("R13 flags", {60'd0, flags_q}, 64'h4);
    run_op(3'd0, 4'd0, 64'd1, 64'd2, 1'b0);
    chk("R13 new flags res", res, 64'd1);

    // sweep: every flag value, code, op and width
    for (int f = 0; f < 16; f++) begin
      set_flags(4'(f));
      chk("R2 sweep flags", {60'd0, flags_q}, 64'(f));
      for (int c = 0; c < 16; c++) begin
        for (int o = 0; o < 8; o++) begin
          for (int w = 0; w < 2; w++) begin
            logic [63:0] a, b;
            a = 64'h9E37_79B9_7F4A_7C15 * 64'(f * 256 + c * 16 + o * 2 + w + 1);
            b = b_pattern(f + c + o + w);
            run_op(3'(o), 4'(c), a, b, w[0]);
            chk(req_cond(4'(c)), {63'd0, cond_pass}, {63'd0, mpass(4'(f), 4'(c))});
            chk(req_res(3'(o), w[0]), res, mres(3'(o), a, b, 4'(f), 4'(c), w[0]));
          end
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule